// File: doc/BRIEF.md
# Unlock-Sequence Command Decoder

This block sits on the device side of a byte-wide parallel flash port. It watches the stream of bus write cycles and turns the guarded multi-write unlock sequences into one-cycle requests. The array and the erase timer sit beside it and take those requests: a byte program with its address and data, an erase of one 4 KB sector with the sector number, or an erase of the whole array. The decoder also tracks the identification mode. While that mode is active, it supplies the manufacturer and device code bytes for the read path.

Every command write is compared only on its low 15 address bits. Higher address bits are don't-care, so one decoder serves every array size. A write that breaks a sequence partway through raises a one-cycle abort and returns the decoder to read mode. If that same write is itself a valid opening write, the decoder restarts at step 1 instead of going idle. While the array reports an internal operation in progress, every write is ignored. This includes the identification exit.

Top module: `wseq_cmd_decoder`

## Requirements
- R1: After reset the decoder is in read mode: `prog_req`, `sect_erase_req`, `chip_erase_req`, `cmd_abort` and `id_mode` are 0, and `id_rdata` is 00h.
- R2: Command cycles compare only address bits 14..0 against 5555h and 2AAAh. Any value in the bits above bit 14 gives the same decode.
- R3: The writes AAh@5555h, 55h@2AAAh and A0h@5555h, followed by one write of any data to any address, raise `prog_req` for one cycle, in the cycle after that fourth write. In that cycle `prog_addr` and `prog_data` hold the full address and the data of the fourth write.
- R4: The writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h and 55h@2AAAh, followed by a sixth write of 30h to any address, raise `sect_erase_req` for one cycle. In that cycle `erase_sector` equals address bits ADDR_W-1..12 of the sixth write.
- R5: The same five-write opening, followed by 10h@5555h, raises `chip_erase_req` for one cycle.
- R6: The writes AAh@5555h, 55h@2AAAh and 90h@5555h set `id_mode`. While `id_mode` is 1, `id_rdata` is BFh when `id_rd_sel` is 0 and DEV_CODE (D7h by default) when `id_rd_sel` is 1. While `id_mode` is 0, `id_rdata` is 00h.
- R7: `id_mode` is cleared either by AAh@5555h, 55h@2AAAh, F0h@5555h, or by a single write of F0h to any address.
- R8: A write that does not fit the sequence after one or more accepted unlock writes raises `cmd_abort` for one cycle and returns to read mode. No request follows from it. A non-command write in read mode raises no abort.
- R9: A mismatching write that is AAh@5555h still raises `cmd_abort`, but counts as step 1 of a new sequence.
- R10: A write made while `busy` is 1 is ignored: it produces no request and no abort, leaves `id_mode` unchanged, and keeps the position reached in a partly entered sequence.
- R11: At most one of `prog_req`, `sect_erase_req`, `chip_erase_req` and `cmd_abort` is 1 in any cycle. A request is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | One-cycle strobe marking one bus write |
| wr_addr | input | ADDR_W | Byte address of the bus write |
| wr_data | input | 8 | Data byte of the bus write |
| busy | input | 1 | Internal program or erase in progress |
| id_rd_sel | input | 1 | Address bit 0 of the current read |
| prog_req | output | 1 | One-cycle byte program request |
| prog_addr | output | ADDR_W | Byte address to program |
| prog_data | output | 8 | Byte to program |
| sect_erase_req | output | 1 | One-cycle sector erase request |
| chip_erase_req | output | 1 | One-cycle whole-array erase request |
| erase_sector | output | ADDR_W-12 | Sector number for the sector erase |
| cmd_abort | output | 1 | One-cycle pulse when a sequence is broken |
| id_mode | output | 1 | Identification mode active |
| id_rdata | output | 8 | Identification byte for the read path |

## Verification
The checker watches a set of properties on every cycle. The requests and the abort must be mutually exclusive and one cycle wide. Any write taken while `busy` is high must stay silent. Each request or change of `id_mode` must be preceded by a write carrying the matching final command byte, and a program request must carry the address and data of the write before it. Whether a whole sequence was recognised, and the cases that depend on history, can only be shown by the bench's scenarios. These cases are the don't-care upper address bits, the restart on a stray AAh@5555h, the resumption of a sequence that was paused under `busy`, and the two forms of the identification exit.

// File: rtl/wseq_pkg.sv
package wseq_pkg;

   // number of address bits compared during command cycles
   localparam int CMP_W = 15;

   localparam logic [CMP_W-1:0] UNLOCK_ADDR_A = 15'h5555;
   localparam logic [CMP_W-1:0] UNLOCK_ADDR_B = 15'h2AAA;

   typedef logic [7:0] cmd_byte_t;

   // index of each recognised command byte in the hit vector
   localparam int K_AA = 0;
   localparam int K_55 = 1;
   localparam int K_A0 = 2;
   localparam int K_80 = 3;
   localparam int K_90 = 4;
   localparam int K_F0 = 5;
   localparam int K_30 = 6;
   localparam int K_10 = 7;
   localparam int NUM_CODES = 8;

   localparam cmd_byte_t CMD_CODES [NUM_CODES] = '{
      8'hAA, 8'h55, 8'hA0, 8'h80, 8'h90, 8'hF0, 8'h30, 8'h10
   };

   // position inside an unlock sequence
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_U1   = 3'd1,
      ST_U2   = 3'd2,
      ST_PGM  = 3'd3,
      ST_E3   = 3'd4,
      ST_E4   = 3'd5,
      ST_E5   = 3'd6
   } step_e;

endpackage

// File: rtl/wseq_match.sv
module wseq_match
   import wseq_pkg::*;
(
   input  logic [CMP_W-1:0]  addr_lo,
   input  cmd_byte_t         data,
   output logic [NUM_CODES-1:0] code_hit,
   output logic              at_a,
   output logic              at_b
);

   for (genvar i = 0; i < NUM_CODES; i++) begin : g_code
      assign code_hit[i] = (data == CMD_CODES[i]);
   end

   assign at_a = (addr_lo == UNLOCK_ADDR_A);
   assign at_b = (addr_lo == UNLOCK_ADDR_B);

endmodule

// File: rtl/wseq_seq_fsm.sv
module wseq_seq_fsm
   import wseq_pkg::*;
#(
   parameter int ADDR_W        = 19,
   parameter int SECTOR_LSB    = 12,
   parameter bit SHORT_EXIT_EN = 1'b1,
   localparam int SECT_W       = ADDR_W - SECTOR_LSB
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 go,
   input  logic [ADDR_W-1:0]    addr,
   input  cmd_byte_t            data,
   input  logic [NUM_CODES-1:0] code_hit,
   input  logic                 at_a,
   input  logic                 at_b,
   output logic                 prog_req,
   output logic [ADDR_W-1:0]    prog_addr,
   output cmd_byte_t            prog_data,
   output logic                 sect_req,
   output logic                 chip_req,
   output logic [SECT_W-1:0]    sector,
   output logic                 abort,
   output logic                 id_set,
   output logic                 id_clr
);

   step_e st_q, st_nxt;
   logic  prog_p, sect_p, chip_p, abort_p, mism;
   logic  first_hit, second_hit, short_exit;

   assign first_hit  = code_hit[K_AA] && at_a;
   assign second_hit = code_hit[K_55] && at_b;

   // the one-write exit form can be removed by parameter
   if (SHORT_EXIT_EN) begin : g_short_exit
      assign short_exit = code_hit[K_F0];
   end else begin : g_no_short_exit
      assign short_exit = 1'b0;
   end

   always_comb begin
      st_nxt  = st_q;
      prog_p  = 1'b0;
      sect_p  = 1'b0;
      chip_p  = 1'b0;
      abort_p = 1'b0;
      id_set  = 1'b0;
      id_clr  = 1'b0;
      mism    = 1'b0;
      if (go) begin
         unique case (st_q)
            ST_IDLE: begin
               if (first_hit)       st_nxt = ST_U1;
               else if (short_exit) id_clr = 1'b1;
            end
            ST_U1: begin
               if (second_hit) st_nxt = ST_U2;
               else            mism   = 1'b1;
            end
            ST_U2: begin
               if (at_a && code_hit[K_A0])      st_nxt = ST_PGM;
               else if (at_a && code_hit[K_80]) st_nxt = ST_E3;
               else if (at_a && code_hit[K_90]) begin
                  id_set = 1'b1;
                  st_nxt = ST_IDLE;
               end else if (at_a && code_hit[K_F0]) begin
                  id_clr = 1'b1;
                  st_nxt = ST_IDLE;
               end else mism = 1'b1;
            end
            ST_PGM: begin
               prog_p = 1'b1;
               st_nxt = ST_IDLE;
            end
            ST_E3: begin
               if (first_hit) st_nxt = ST_E4;
               else           mism   = 1'b1;
            end
            ST_E4: begin
               if (second_hit) st_nxt = ST_E5;
               else            mism   = 1'b1;
            end
            ST_E5: begin
               if (code_hit[K_30]) begin
                  sect_p = 1'b1;
                  st_nxt = ST_IDLE;
               end else if (at_a && code_hit[K_10]) begin
                  chip_p = 1'b1;
                  st_nxt = ST_IDLE;
               end else mism = 1'b1;
            end
            default: st_nxt = ST_IDLE;
         endcase
         if (mism) begin
            abort_p = 1'b1;
            st_nxt  = first_hit ? ST_U1 : ST_IDLE;
            if (short_exit) id_clr = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         prog_req  <= 1'b0;
         sect_req  <= 1'b0;
         chip_req  <= 1'b0;
         abort     <= 1'b0;
         prog_addr <= '0;
         prog_data <= '0;
         sector    <= '0;
      end else begin
         st_q     <= st_nxt;
         prog_req <= prog_p;
         sect_req <= sect_p;
         chip_req <= chip_p;
         abort    <= abort_p;
         if (prog_p) begin
            prog_addr <= addr;
            prog_data <= data;
         end
         if (sect_p) sector <= addr[ADDR_W-1:SECTOR_LSB];
      end
   end

endmodule

// File: rtl/wseq_id_reg.sv
module wseq_id_reg
   import wseq_pkg::*;
#(
   parameter cmd_byte_t MFR_CODE = 8'hBF,
   parameter cmd_byte_t DEV_CODE = 8'hD7
)(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      id_set,
   input  logic      id_clr,
   input  logic      rd_sel,
   output logic      id_mode,
   output cmd_byte_t id_rdata
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      id_mode <= 1'b0;
      else if (id_set) id_mode <= 1'b1;
      else if (id_clr) id_mode <= 1'b0;
   end

   always_comb begin
      if (!id_mode)    id_rdata = 8'h00;
      else if (rd_sel) id_rdata = DEV_CODE;
      else             id_rdata = MFR_CODE;
   end

endmodule

// File: rtl/wseq_cmd_decoder.sv
module wseq_cmd_decoder
   import wseq_pkg::*;
#(
   parameter int        ADDR_W        = 19,
   parameter int        SECTOR_LSB    = 12,
   parameter bit        SHORT_EXIT_EN = 1'b1,
   parameter cmd_byte_t MFR_CODE      = 8'hBF,
   parameter cmd_byte_t DEV_CODE      = 8'hD7,
   localparam int       SECT_W        = ADDR_W - SECTOR_LSB
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic              busy,
   input  logic              id_rd_sel,
   output logic              prog_req,
   output logic [ADDR_W-1:0] prog_addr,
   output logic [7:0]        prog_data,
   output logic              sect_erase_req,
   output logic              chip_erase_req,
   output logic [SECT_W-1:0] erase_sector,
   output logic              cmd_abort,
   output logic              id_mode,
   output logic [7:0]        id_rdata
);

   if (ADDR_W < CMP_W) begin : g_bad_addr_w
      $error("ADDR_W must be at least the compared width");
   end
   if (SECTOR_LSB < 1 || SECTOR_LSB >= ADDR_W) begin : g_bad_sector
      $error("SECTOR_LSB must lie inside the address");
   end

   logic [NUM_CODES-1:0] code_hit;
   logic                 at_a, at_b, go, id_set, id_clr;

   assign go = wr_en && !busy;

   wseq_match u_match (
      .addr_lo  (wr_addr[CMP_W-1:0]),
      .data     (wr_data),
      .code_hit (code_hit),
      .at_a     (at_a),
      .at_b     (at_b)
   );

   wseq_seq_fsm #(
      .ADDR_W        (ADDR_W),
      .SECTOR_LSB    (SECTOR_LSB),
      .SHORT_EXIT_EN (SHORT_EXIT_EN)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (go),
      .addr      (wr_addr),
      .data      (wr_data),
      .code_hit  (code_hit),
      .at_a      (at_a),
      .at_b      (at_b),
      .prog_req  (prog_req),
      .prog_addr (prog_addr),
      .prog_data (prog_data),
      .sect_req  (sect_erase_req),
      .chip_req  (chip_erase_req),
      .sector    (erase_sector),
      .abort     (cmd_abort),
      .id_set    (id_set),
      .id_clr    (id_clr)
   );

   wseq_id_reg #(
      .MFR_CODE (MFR_CODE),
      .DEV_CODE (DEV_CODE)
   ) u_id (
      .clk      (clk),
      .rst_n    (rst_n),
      .id_set   (id_set),
      .id_clr   (id_clr),
      .rd_sel   (id_rd_sel),
      .id_mode  (id_mode),
      .id_rdata (id_rdata)
   );

endmodule

// File: rtl/wseq_chk.sv
module wseq_chk #(
   parameter int ADDR_W = 19
)(
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [7:0]        wr_data,
   input logic              busy,
   input logic              prog_req,
   input logic [ADDR_W-1:0] prog_addr,
   input logic [7:0]        prog_data,
   input logic              sect_erase_req,
   input logic              chip_erase_req,
   input logic              cmd_abort,
   input logic              id_mode
);

   logic any_req;
   assign any_req = prog_req || sect_erase_req || chip_erase_req;

   p_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({prog_req, sect_erase_req, chip_erase_req, cmd_abort}));

   p_single_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      any_req |=> !any_req);

   p_busy_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && busy) |=> (!any_req && !cmd_abort && $stable(id_mode)));

   p_prog_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
      prog_req |-> ($past(wr_en && !busy) && prog_addr == $past(wr_addr)
                    && prog_data == $past(wr_data)));

   p_sect_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sect_erase_req |-> $past(wr_en && !busy && wr_data == 8'h30));

   p_chip_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
      chip_erase_req |-> $past(wr_en && !busy && wr_data == 8'h10
                               && wr_addr[14:0] == 15'h5555));

   p_id_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(id_mode) |-> $past(wr_en && !busy && wr_data == 8'h90
                               && wr_addr[14:0] == 15'h5555));

   p_id_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(id_mode) |-> $past(wr_en && !busy && wr_data == 8'hF0));

   p_abort_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_abort |-> $past(wr_en && !busy));

endmodule

bind wseq_cmd_decoder wseq_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .wr_en          (wr_en),
   .wr_addr        (wr_addr),
   .wr_data        (wr_data),
   .busy           (busy),
   .prog_req       (prog_req),
   .prog_addr      (prog_addr),
   .prog_data      (prog_data),
   .sect_erase_req (sect_erase_req),
   .chip_erase_req (chip_erase_req),
   .cmd_abort      (cmd_abort),
   .id_mode        (id_mode)
);

// File: tb/tb_wseq_cmd_decoder.sv
module tb_wseq_cmd_decoder;

   localparam int AW = 19;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [7:0]    wr_data = '0;
   logic          busy = 1'b0;
   logic          id_rd_sel = 1'b0;
   logic          prog_req, sect_erase_req, chip_erase_req, cmd_abort, id_mode;
   logic [AW-1:0] prog_addr;
   logic [7:0]    prog_data, id_rdata;
   logic [AW-13:0] erase_sector;

   int n_chk = 0;
   int n_bad = 0;

   // outputs seen right after the edge that took the write, and one cycle later
   logic          c_prog, c_sect, c_chip, c_abort, c_next_any;
   logic [AW-1:0] c_paddr;
   logic [7:0]    c_pdata;
   logic [AW-13:0] c_sector;

   always #5 clk = ~clk;

   wseq_cmd_decoder dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .wr_en          (wr_en),
      .wr_addr        (wr_addr),
      .wr_data        (wr_data),
      .busy           (busy),
      .id_rd_sel      (id_rd_sel),
      .prog_req       (prog_req),
      .prog_addr      (prog_addr),
      .prog_data      (prog_data),
      .sect_erase_req (sect_erase_req),
      .chip_erase_req (chip_erase_req),
      .erase_sector   (erase_sector),
      .cmd_abort      (cmd_abort),
      .id_mode        (id_mode),
      .id_rdata       (id_rdata)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk); #1;
      c_prog = prog_req; c_sect = sect_erase_req; c_chip = chip_erase_req;
      c_abort = cmd_abort; c_paddr = prog_addr; c_pdata = prog_data;
      c_sector = erase_sector;
      @(negedge clk);
      wr_en = 1'b0;
      @(posedge clk); #1;
      c_next_any = prog_req | sect_erase_req | chip_erase_req | cmd_abort;
   endtask

   task automatic prefix(input logic [AW-1:0] hi);
      wr(hi | 19'h05555, 8'hAA);
      wr(hi | 19'h02AAA, 8'h55);
   endtask

   task automatic erase_open();
      prefix('0);
      wr(19'h05555, 8'h80);
      prefix('0);
   endtask

   task automatic t_reset();
      chk("R1 prog_req", prog_req, 0);
      chk("R1 sect_erase_req", sect_erase_req, 0);
      chk("R1 chip_erase_req", chip_erase_req, 0);
      chk("R1 cmd_abort", cmd_abort, 0);
      chk("R1 id_mode", id_mode, 0);
      chk("R1 id_rdata", id_rdata, 8'h00);
   endtask

   task automatic t_program();
      prefix('0);
      wr(19'h05555, 8'hA0);
      chk("R3 no request after third write", c_prog, 0);
      wr(19'h41234, 8'h3C);
      chk("R3 prog_req", c_prog, 1);
      chk("R3 prog_addr", c_paddr, 19'h41234);
      chk("R3 prog_data", c_pdata, 8'h3C);
      chk("R11 no erase with program", c_sect | c_chip | c_abort, 0);
      chk("R11 pulse one cycle", c_next_any, 0);
   endtask

   task automatic t_upper_bits();
      prefix(19'h78000);
      wr(19'h7D555, 8'hA0);
      wr(19'h00007, 8'hE1);
      chk("R2 program with upper bits set", c_prog, 1);
      chk("R2 prog_data", c_pdata, 8'hE1);
   endtask

   task automatic t_sector();
      erase_open();
      wr(19'h53ABC, 8'h30);
      chk("R4 sect_erase_req", c_sect, 1);
      chk("R4 erase_sector", c_sector, 7'h53);
      chk("R4 no chip erase", c_chip, 0);
      chk("R11 sector pulse one cycle", c_next_any, 0);
   endtask

   task automatic t_chip();
      erase_open();
      wr(19'h7D555, 8'h10);
      chk("R5 chip_erase_req", c_chip, 1);
      chk("R5 no sector erase", c_sect, 0);
      chk("R11 chip pulse one cycle", c_next_any, 0);
   endtask

   task automatic t_id_entry();
      prefix('0);
      wr(19'h05555, 8'h90);
      chk("R6 id_mode set", id_mode, 1);
      id_rd_sel = 1'b0; #1;
      chk("R6 manufacturer code", id_rdata, 8'hBF);
      id_rd_sel = 1'b1; #1;
      chk("R6 device code", id_rdata, 8'hD7);
      id_rd_sel = 1'b0;
   endtask

   task automatic t_exit_long();
      prefix('0);
      wr(19'h05555, 8'hF0);
      chk("R7 long exit", id_mode, 0);
      chk("R6 id_rdata outside ID mode", id_rdata, 8'h00);
   endtask

   task automatic t_exit_short();
      wr(19'h01234, 8'hF0);
      chk("R7 single-write exit", id_mode, 0);
      chk("R8 no abort for idle write", c_abort, 0);
   endtask

   task automatic t_abort();
      prefix('0);
      wr(19'h05555, 8'h12);
      chk("R8 abort on bad third write", c_abort, 1);
      wr(19'h01000, 8'h77);
      chk("R8 no program after abort", c_prog, 0);
      chk("R8 idle write raises no abort", c_abort, 0);
      erase_open();
      wr(19'h05555, 8'h20);
      chk("R8 abort on bad sixth write", c_abort, 1);
      chk("R8 no erase after bad sixth", c_sect | c_chip, 0);
      wr(19'h01000, 8'h30);
      chk("R8 stray 30h in read mode", c_sect, 0);
   endtask

   task automatic t_restart();
      prefix('0);
      wr(19'h05555, 8'hAA);
      chk("R9 abort on restart write", c_abort, 1);
      wr(19'h02AAA, 8'h55);
      wr(19'h05555, 8'hA0);
      wr(19'h02222, 8'h5A);
      chk("R9 program after restart", c_prog, 1);
      chk("R9 prog_addr", c_paddr, 19'h02222);
   endtask

   task automatic t_busy();
      busy = 1'b1;
      prefix('0);
      wr(19'h05555, 8'hA0);
      wr(19'h01111, 8'h01);
      chk("R10 no program while busy", c_prog, 0);
      busy = 1'b0;
      prefix('0);
      busy = 1'b1;
      wr(19'h05555, 8'h12);
      chk("R10 no abort while busy", c_abort, 0);
      busy = 1'b0;
      wr(19'h05555, 8'hA0);
      wr(19'h03333, 8'h99);
      chk("R10 sequence position kept", c_prog, 1);
      prefix('0);
      wr(19'h05555, 8'h90);
      busy = 1'b1;
      wr(19'h05555, 8'hF0);
      chk("R10 ID exit ignored while busy", id_mode, 1);
      busy = 1'b0;
      wr(19'h05555, 8'hF0);
      chk("R7 exit after busy clears", id_mode, 0);
   endtask

   initial begin
      #2_000_000;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #1;
      t_reset();
      t_program();
      t_upper_bits();
      t_sector();
      t_chip();
      t_id_entry();
      t_exit_long();
      t_id_entry();
      t_exit_short();
      t_abort();
      t_restart();
      t_busy();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule